// File: doc/BRIEF.md
# Multi-Grant Interrupt Source Aggregator

This block collects a parameterised set of level-sensitive interrupt lines and turns them into one interrupt request for a processor. A source cannot raise an interrupt through its line alone. It has to collect a configured number of separate enable grants first, because in a larger controller each source may be gated by several mask or priority fields at once. Grant and revoke pulses move a small per-source counter. The source is enabled only while that counter equals its configured requirement.

A source is pending when its line is high and it is enabled. The block keeps a running count of pending sources and holds the processor request high while that count is nonzero. Several sources may change in the same clock, so the count moves by the number of sources that became pending minus the number that stopped being pending.

A vector query presents the configured vector of the lowest-numbered pending source, with a valid flag. When the processor's interrupt mask input is at its all-ones value, the query reports no vector. Each source's vector and grant requirement arrive as configuration inputs, which are expected to stay static while the block runs.

Top module: `intc_src_aggregator`

## Requirements
- R1: While reset is active and on the first cycle after it, the pending count is 0, the interrupt request is low, the vector valid flag is low and the vector is all ones.
- R2: A grant pulse raises a source's enable counter by one. A grant that arrives while the counter already equals the source's requirement has no effect, so one later revoke is enough to disable the source.
- R3: A revoke pulse is ignored unless the source's counter equals its requirement. When it does, the counter drops by one.
- R4: A source is pending exactly when its line is high at a clock edge and its counter equals its requirement. A source whose requirement is 0 is always enabled and ignores revokes.
- R5: The pending count equals the number of pending sources and is updated on the same edge as the source states, including when several sources rise and fall in the same cycle.
- R6: The interrupt request is high exactly when the pending count is nonzero.
- R7: When the mask input is not all ones and at least one source is pending, the valid flag is high and the vector equals the configured vector of the pending source with the lowest index.
- R8: When the mask input is all ones, the valid flag is low and the vector is all ones, whatever is pending. The interrupt request is not affected.
- R9: When no source is pending, the valid flag is low and the vector is all ones.
- R10: If a grant and a revoke reach a source in the same cycle while its counter equals its requirement, the revoke is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_level | input | N_SRC | Interrupt line level of each source |
| en_grant | input | N_SRC | One-cycle pulse adding one enable grant to a source |
| en_revoke | input | N_SRC | One-cycle pulse removing one enable grant from a source |
| cfg_vec | input | N_SRC*VEC_W | Vector of each source; source i occupies bits i*VEC_W and up |
| cfg_en_max | input | N_SRC*EN_W | Number of grants each source needs; source i occupies bits i*EN_W and up |
| cpu_mask | input | MASK_W | Processor interrupt mask level; all ones blocks the vector query |
| cpu_irq | output | 1 | Interrupt request to the processor |
| pend_count | output | clog2(N_SRC+1) | Number of pending sources |
| vec_out | output | VEC_W | Vector of the lowest-index pending source, all ones when not valid |
| vec_valid | output | 1 | Vector output is meaningful |

## Verification
The assertions assume that the grant requirements and vectors stay constant after reset and that no source is granted past a value its counter can hold. Under those conditions the pending count can never go above the number of sources or fall below zero. The stimulus sets the configuration once before reset is released and never changes it. Every grant and revoke is a single-cycle pulse driven between clock edges. Since grants that exceed the requirement are ignored, no sequence of pulses can break these assumptions.

// File: rtl/intc_agg_pkg.sv
package intc_agg_pkg;

   // Update chosen for one source's enable counter in a cycle
   typedef enum logic [1:0] {
      EN_HOLD = 2'd0,
      EN_UP   = 2'd1,
      EN_DOWN = 2'd2
   } en_act_e;

   // Width needed to hold a count from 0 to n inclusive
   function automatic int count_width(input int n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/intc_src_slot.sv
module intc_src_slot
   import intc_agg_pkg::*;
#(
   parameter int EN_W = 2
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            level,
   input  logic            grant,
   input  logic            revoke,
   input  logic [EN_W-1:0] cfg_max,
   output logic            pend_q,
   output logic            rise,
   output logic            fall
);

   logic [EN_W-1:0] cnt_q;
   logic [EN_W-1:0] cnt_d;
   logic            at_max;
   logic            pend_d;
   en_act_e         act;

   assign at_max = (cnt_q == cfg_max);

   // Revoke has priority and only acts when the source is fully enabled.
   // A zero requirement means always enabled, so revokes are dropped there.
   always_comb begin
      act = EN_HOLD;
      if (revoke && at_max && (cfg_max != '0)) begin
         act = EN_DOWN;
      end else if (grant && !at_max) begin
         act = EN_UP;
      end
   end

   always_comb begin
      unique case (act)
         EN_UP:   cnt_d = cnt_q + EN_W'(1);
         EN_DOWN: cnt_d = cnt_q - EN_W'(1);
         default: cnt_d = cnt_q;
      endcase
   end

   assign pend_d = level && (cnt_d == cfg_max);
   assign rise   = pend_d && !pend_q;
   assign fall   = !pend_d && pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         pend_q <= 1'b0;
      end else begin
         cnt_q  <= cnt_d;
         pend_q <= pend_d;
      end
   end

endmodule

// File: rtl/intc_pend_counter.sv
module intc_pend_counter #(
   parameter int N_SRC = 8,
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] rise,
   input  logic [N_SRC-1:0] fall,
   output logic [CNT_W-1:0] count_q,
   output logic             irq_q
);

   localparam int SUM_W = CNT_W + 1;

   logic [SUM_W-1:0] ups;
   logic [SUM_W-1:0] dns;
   logic [SUM_W-1:0] sum;
   logic [CNT_W-1:0] count_d;

   // Net change applied once per clock, however many sources moved
   always_comb begin
      ups = '0;
      dns = '0;
      for (int i = 0; i < N_SRC; i++) begin
         ups = ups + SUM_W'(rise[i]);
         dns = dns + SUM_W'(fall[i]);
      end
      sum     = {1'b0, count_q} + ups - dns;
      count_d = sum[CNT_W-1:0];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         count_q <= '0;
         irq_q   <= 1'b0;
      end else begin
         count_q <= count_d;
         irq_q   <= (count_d != '0);
      end
   end

endmodule

// File: rtl/intc_vec_scan.sv
module intc_vec_scan #(
   parameter int N_SRC  = 8,
   parameter int VEC_W  = 12,
   parameter int MASK_W = 4
) (
   input  logic [N_SRC-1:0]       pend,
   input  logic [N_SRC*VEC_W-1:0] cfg_vec,
   input  logic [MASK_W-1:0]      cpu_mask,
   output logic [VEC_W-1:0]       vec_out,
   output logic                   vec_valid
);

   logic             found;
   logic [VEC_W-1:0] pick;
   logic             blocked;

   assign blocked = (cpu_mask == {MASK_W{1'b1}});

   // Walk from the top down so the lowest pending index is left in pick
   always_comb begin
      found = 1'b0;
      pick  = '1;
      for (int i = N_SRC - 1; i >= 0; i--) begin
         if (pend[i]) begin
            found = 1'b1;
            pick  = cfg_vec[i*VEC_W +: VEC_W];
         end
      end
   end

   assign vec_valid = found && !blocked;
   assign vec_out   = vec_valid ? pick : '1;

endmodule

// File: rtl/intc_src_aggregator.sv
module intc_src_aggregator
   import intc_agg_pkg::*;
#(
   parameter int N_SRC  = 8,
   parameter int VEC_W  = 12,
   parameter int EN_W   = 2,
   parameter int MASK_W = 4
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [N_SRC-1:0]                    src_level,
   input  logic [N_SRC-1:0]                    en_grant,
   input  logic [N_SRC-1:0]                    en_revoke,
   input  logic [N_SRC*VEC_W-1:0]              cfg_vec,
   input  logic [N_SRC*EN_W-1:0]               cfg_en_max,
   input  logic [MASK_W-1:0]                   cpu_mask,
   output logic                                cpu_irq,
   output logic [count_width(N_SRC)-1:0]       pend_count,
   output logic [VEC_W-1:0]                    vec_out,
   output logic                                vec_valid
);

   localparam int CNT_W = count_width(N_SRC);

   if (N_SRC < 1) begin : g_bad_nsrc
      $error("intc_src_aggregator: N_SRC must be at least 1");
   end
   if (VEC_W < 1) begin : g_bad_vecw
      $error("intc_src_aggregator: VEC_W must be at least 1");
   end
   if (EN_W < 1) begin : g_bad_enw
      $error("intc_src_aggregator: EN_W must be at least 1");
   end
   if (MASK_W < 1) begin : g_bad_maskw
      $error("intc_src_aggregator: MASK_W must be at least 1");
   end

   logic [N_SRC-1:0] pend;
   logic [N_SRC-1:0] rise;
   logic [N_SRC-1:0] fall;

   for (genvar g = 0; g < N_SRC; g++) begin : g_slot
      intc_src_slot #(
         .EN_W(EN_W)
      ) u_slot (
         .clk     (clk),
         .rst_n   (rst_n),
         .level   (src_level[g]),
         .grant   (en_grant[g]),
         .revoke  (en_revoke[g]),
         .cfg_max (cfg_en_max[g*EN_W +: EN_W]),
         .pend_q  (pend[g]),
         .rise    (rise[g]),
         .fall    (fall[g])
      );
   end

   intc_pend_counter #(
      .N_SRC(N_SRC),
      .CNT_W(CNT_W)
   ) u_count (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise    (rise),
      .fall    (fall),
      .count_q (pend_count),
      .irq_q   (cpu_irq)
   );

   intc_vec_scan #(
      .N_SRC (N_SRC),
      .VEC_W (VEC_W),
      .MASK_W(MASK_W)
   ) u_scan (
      .pend      (pend),
      .cfg_vec   (cfg_vec),
      .cpu_mask  (cpu_mask),
      .vec_out   (vec_out),
      .vec_valid (vec_valid)
   );

endmodule

// File: rtl/intc_agg_chk.sv
module intc_agg_chk #(
   parameter int N_SRC  = 8,
   parameter int VEC_W  = 12,
   parameter int MASK_W = 4,
   parameter int CNT_W  = 4
) (
   input logic              clk,
   input logic              rst_n,
   input logic [N_SRC-1:0]  src_level,
   input logic [MASK_W-1:0] cpu_mask,
   input logic              cpu_irq,
   input logic [CNT_W-1:0]  pend_count,
   input logic [VEC_W-1:0]  vec_out,
   input logic              vec_valid
);

   AST_IRQ_FOLLOWS_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_irq == (pend_count != '0));                                           // R6

   AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      pend_count <= CNT_W'(N_SRC));                                             // R5

   AST_PEND_NEEDS_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_count != '0) |-> (|$past(src_level)));                              // R4

   AST_VALID_NEEDS_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      vec_valid |-> cpu_irq);                                                   // R7

   AST_MASK_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
      (cpu_mask == {MASK_W{1'b1}}) |-> (!vec_valid && vec_out == {VEC_W{1'b1}})); // R8

   AST_IDLE_ALL_ONES: assert property (@(posedge clk) disable iff (!rst_n)
      !vec_valid |-> (vec_out == {VEC_W{1'b1}}));                               // R9

endmodule

bind intc_src_aggregator intc_agg_chk #(
   .N_SRC (N_SRC),
   .VEC_W (VEC_W),
   .MASK_W(MASK_W),
   .CNT_W (intc_agg_pkg::count_width(N_SRC))
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .src_level  (src_level),
   .cpu_mask   (cpu_mask),
   .cpu_irq    (cpu_irq),
   .pend_count (pend_count),
   .vec_out    (vec_out),
   .vec_valid  (vec_valid)
);

// File: tb/tb_intc_src_aggregator.sv
module tb_intc_src_aggregator;

   localparam int N  = 8;
   localparam int VW = 12;
   localparam int EW = 2;
   localparam int MW = 4;
   localparam int CW = 4;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [N-1:0]    src_level = '0;
   logic [N-1:0]    en_grant = '0;
   logic [N-1:0]    en_revoke = '0;
   logic [N*VW-1:0] cfg_vec;
   logic [N*EW-1:0] cfg_en_max;
   logic [MW-1:0]   cpu_mask = '0;
   logic            cpu_irq;
   logic [CW-1:0]   pend_count;
   logic [VW-1:0]   vec_out;
   logic            vec_valid;

   int n_checks = 0;
   int n_fail   = 0;

   always #4 clk = ~clk;

   intc_src_aggregator #(.N_SRC(N), .VEC_W(VW), .EN_W(EW), .MASK_W(MW)) dut (
      .clk(clk), .rst_n(rst_n), .src_level(src_level), .en_grant(en_grant),
      .en_revoke(en_revoke), .cfg_vec(cfg_vec), .cfg_en_max(cfg_en_max),
      .cpu_mask(cpu_mask), .cpu_irq(cpu_irq), .pend_count(pend_count),
      .vec_out(vec_out), .vec_valid(vec_valid)
   );

   // Source i: vector 0x100 + 17*i, requirement i mod 4
   initial begin
      for (int i = 0; i < N; i++) begin
         cfg_vec[i*VW +: VW]    = VW'(12'h100 + 17 * i);
         cfg_en_max[i*EW +: EW] = EW'(i % 4);
      end
   end

   typedef struct packed {
      logic [7:0]  lvl;
      logic [7:0]  gnt;
      logic [7:0]  rvk;
      logic [3:0]  mask;
      logic [3:0]  cnt;
      logic        valid;
      logic [11:0] vec;
   } row_t;

   localparam row_t ROWS [9] = '{
      '{8'h00, 8'h00, 8'h00, 4'h0, 4'd0, 1'b0, 12'hFFF},
      '{8'h10, 8'h00, 8'h00, 4'h0, 4'd1, 1'b1, 12'h144},
      '{8'h11, 8'h00, 8'h00, 4'h3, 4'd2, 1'b1, 12'h100},
      '{8'h11, 8'h00, 8'h00, 4'hF, 4'd2, 1'b0, 12'hFFF},
      '{8'h22, 8'h00, 8'h00, 4'h0, 4'd0, 1'b0, 12'hFFF},
      '{8'h22, 8'h22, 8'h00, 4'h0, 4'd2, 1'b1, 12'h111},
      '{8'h22, 8'h00, 8'h02, 4'h0, 4'd1, 1'b1, 12'h155},
      '{8'h22, 8'h02, 8'h20, 4'h0, 4'd1, 1'b1, 12'h111},
      '{8'h00, 8'h00, 8'h00, 4'h0, 4'd0, 1'b0, 12'hFFF}
   };

   task automatic chk(input string req, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   // Called at a falling edge: drive, let one rising edge pass, return at next falling edge
   task automatic apply(input logic [7:0] lvl, input logic [7:0] gnt,
                        input logic [7:0] rvk, input logic [3:0] mask);
      src_level = lvl;
      en_grant  = gnt;
      en_revoke = rvk;
      cpu_mask  = mask;
      @(negedge clk);
      en_grant  = '0;
      en_revoke = '0;
   endtask

   task automatic expect_out(input string req, input int cnt, input int vec);
      chk({req, " count"}, int'(pend_count), cnt);
      chk({req, " irq"}, int'(cpu_irq), int'(cnt != 0));
      chk({req, " valid"}, int'(vec_valid), int'(vec != 12'hFFF));
      chk({req, " vector"}, int'(vec_out), vec);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state
      expect_out("R1 in reset", 0, 12'hFFF);
      rst_n = 1'b1;
      @(negedge clk);
      expect_out("R1 after reset", 0, 12'hFFF);

      // Table walk: R5 R6 R7 R8 R9
      for (int r = 0; r < 9; r++) begin
         string tag;
         apply(ROWS[r].lvl, ROWS[r].gnt, ROWS[r].rvk, ROWS[r].mask);
         if (ROWS[r].mask == 4'hF)  tag = "R8";
         else if (!ROWS[r].valid)   tag = "R9";
         else                       tag = "R7";
         chk("R5 table count", int'(pend_count), int'(ROWS[r].cnt));
         chk("R6 table irq", int'(cpu_irq), int'(ROWS[r].cnt != 0));
         chk({tag, " table valid"}, int'(vec_valid), int'(ROWS[r].valid));
         chk({tag, " table vector"}, int'(vec_out), int'(ROWS[r].vec));
      end

      // R2: source 3 needs 3 grants; a fourth grant is ignored
      repeat (4) apply(8'h00, 8'h08, 8'h00, 4'h0);
      apply(8'h08, 8'h00, 8'h00, 4'h0);
      expect_out("R2 saturated grant", 1, 12'h133);
      apply(8'h08, 8'h00, 8'h08, 4'h0);
      expect_out("R2 single revoke disables", 0, 12'hFFF);
      apply(8'h08, 8'h08, 8'h00, 4'h0);
      expect_out("R2 regrant", 1, 12'h133);
      apply(8'h00, 8'h00, 8'h00, 4'h0);

      // R3: source 2 needs 2; a revoke below the requirement is ignored
      apply(8'h04, 8'h04, 8'h00, 4'h0);
      expect_out("R3 partial grant", 0, 12'hFFF);
      apply(8'h04, 8'h00, 8'h04, 4'h0);
      expect_out("R3 revoke below max", 0, 12'hFFF);
      apply(8'h04, 8'h04, 8'h00, 4'h0);
      expect_out("R3 second grant enables", 1, 12'h122);
      apply(8'h00, 8'h00, 8'h00, 4'h0);

      // R10: source 6, grant and revoke together at max
      apply(8'h40, 8'h40, 8'h00, 4'h0);
      apply(8'h40, 8'h40, 8'h00, 4'h0);
      expect_out("R10 enabled", 1, 12'h166);
      apply(8'h40, 8'h40, 8'h40, 4'h0);
      expect_out("R10 revoke wins", 0, 12'hFFF);
      apply(8'h40, 8'h40, 8'h00, 4'h0);
      expect_out("R10 regrant", 1, 12'h166);
      apply(8'h00, 8'h00, 8'h00, 4'h0);

      // R4: zero requirement, revoke ignored
      apply(8'h01, 8'h00, 8'h01, 4'h0);
      expect_out("R4 zero requirement", 1, 12'h100);
      apply(8'h00, 8'h00, 8'h00, 4'h0);
      expect_out("R4 line low", 0, 12'hFFF);

      // R5: all sources pending together
      repeat (3) apply(8'h00, 8'hFF, 8'h00, 4'h0);
      apply(8'hFF, 8'h00, 8'h00, 4'h0);
      expect_out("R5 all pending", 8, 12'h100);
      apply(8'hFF, 8'h00, 8'h00, 4'hF);
      expect_out("R8 mask blocks", 8, 12'hFFF);
      chk("R8 irq kept", int'(cpu_irq), 1);
      apply(8'h00, 8'h00, 8'h00, 4'h0);
      expect_out("R5 all drop", 0, 12'hFFF);

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

   initial begin
      #(8 * 200000);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
   end

endmodule